// File: doc/BRIEF.md
# Register with Selectable Asynchronous Controls

This block is a W-bit register that captures its synchronous data input on the rising clock edge. It also has two active-low asynchronous control lines, `ctl_a_n` and `ctl_b_n`. A build-time parameter picks one of six control modes, and the mode decides what each line does. A line can force the register to zero, force it to all ones, or copy a separate load-data word into it. These effects happen as soon as the line falls, with no wait for a clock edge.

Each mode routes the two lines to three internal active-low signals: clear, preset and load. A control that the chosen mode does not use is tied high, so it stays inactive. When more than one control is active, clear wins over preset, and preset wins over load. The synchronous data path only acts when none of the three is active.

The block suits a datapath or control register that needs a power-on value, a forced value or an asynchronously loaded seed. The designer chooses the control behaviour when the block is built.

Top module: `regctl_async_reg`

## Requirements
- R1: While none of the mode's active controls is asserted, the register takes `d` at each rising edge of `clk`.
- R2: A low level on the line that acts as clear (mode `RC_CLR` and `RC_CLR_PRE`: `ctl_a_n`; mode `RC_LD_CLR`: `ctl_b_n`) drives `q` to all zeros at once, between clock edges.
- R3: A low level on the line that acts as preset (mode `RC_PRE`: `ctl_a_n`; `RC_CLR_PRE` and `RC_LD_PRE`: `ctl_b_n`) drives `q` to all ones at once.
- R4: In mode `RC_CLR`, the parameter `CLR_ON_B` picks the clear line: 0 selects `ctl_a_n`, 1 selects `ctl_b_n`.
- R5: In the three load modes (`RC_LD_CLR`, `RC_LD_PRE`, `RC_LD`), a low level on `ctl_a_n` copies `ld_d` into `q` at once.
- R6: In `RC_LD_CLR` and `RC_LD_PRE`, `ctl_b_n` is the clear or the preset, and it overrides a load that is asserted at the same time.
- R7: In `RC_CLR_PRE`, when clear and preset are both asserted, `q` is all zeros.
- R8: A line that the mode does not use has no effect on `q` (`ctl_b_n` in `RC_PRE`, `RC_LD` and `RC_CLR` with `CLR_ON_B=0`; `ctl_a_n` in `RC_CLR` with `CLR_ON_B=1`).
- R9: While a control stays asserted, a clock edge does not replace the forced value with `d`. A held load keeps `q` equal to `ld_d`.
- R10: If the controls are released before a clock edge, that edge captures `d`. If they are released just after an edge, `q` keeps the forced value until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| d | input | W | Synchronous data |
| ld_d | input | W | Asynchronous load data |
| ctl_a_n | input | 1 | First active-low control line (role set by mode) |
| ctl_b_n | input | 1 | Second active-low control line (role set by mode) |
| q | output | W | Register contents |

## Verification
The bench builds seven copies with W=4: one for each of the six modes, plus a second clear-only copy with `CLR_ON_B=1`. All seven share the same stimulus. At four bits, every load-data value and every combination of the two control lines can be applied in every mode. This makes the priority, ignored-line and hold behaviour checkable exhaustively. Controls are asserted mid-cycle, released one time unit before an edge and released just after an edge, so the timing corners of R9 and R10 are covered.

// File: rtl/regctl_pkg.sv
package regctl_pkg;
  typedef enum logic [2:0] {
    RC_CLR     = 3'd0,
    RC_PRE     = 3'd1,
    RC_CLR_PRE = 3'd2,
    RC_LD_CLR  = 3'd3,
    RC_LD_PRE  = 3'd4,
    RC_LD      = 3'd5
  } rc_mode_e;
endpackage

// File: rtl/regctl_route.sv
// Maps the two shared control lines to clear/preset/load per mode.
// Controls not used by the mode are tied high (inactive).
module regctl_route #(
  parameter regctl_pkg::rc_mode_e MODE = regctl_pkg::RC_CLR_PRE,
  parameter bit CLR_ON_B = 1'b0
) (
  input  logic ctl_a_n,
  input  logic ctl_b_n,
  output logic clr_n,
  output logic pre_n,
  output logic ld_n
);
  generate
    if (MODE == regctl_pkg::RC_CLR) begin : g_clr
      if (CLR_ON_B) begin : g_b
        assign clr_n = ctl_b_n;
      end else begin : g_a
        assign clr_n = ctl_a_n;
      end
      assign pre_n = 1'b1;
      assign ld_n  = 1'b1;
    end else if (MODE == regctl_pkg::RC_PRE) begin : g_pre
      assign clr_n = 1'b1;
      assign pre_n = ctl_a_n;
      assign ld_n  = 1'b1;
    end else if (MODE == regctl_pkg::RC_CLR_PRE) begin : g_clr_pre
      assign clr_n = ctl_a_n;
      assign pre_n = ctl_b_n;
      assign ld_n  = 1'b1;
    end else if (MODE == regctl_pkg::RC_LD_CLR) begin : g_ld_clr
      assign clr_n = ctl_b_n;
      assign pre_n = 1'b1;
      assign ld_n  = ctl_a_n;
    end else if (MODE == regctl_pkg::RC_LD_PRE) begin : g_ld_pre
      assign clr_n = 1'b1;
      assign pre_n = ctl_b_n;
      assign ld_n  = ctl_a_n;
    end else begin : g_ld
      assign clr_n = 1'b1;
      assign pre_n = 1'b1;
      assign ld_n  = ctl_a_n;
    end
  endgenerate
endmodule

// File: rtl/regctl_cell.sv
// W bit slices, each a flop with async clear > preset > load.
module regctl_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  input  logic [W-1:0] ld_d,
  input  logic         clr_n,
  input  logic         pre_n,
  input  logic         ld_n,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_r;
      always_ff @(posedge clk or negedge clr_n or negedge pre_n or negedge ld_n) begin
        if (!clr_n)      bit_r <= 1'b0;
        else if (!pre_n) bit_r <= 1'b1;
        else if (!ld_n)  bit_r <= ld_d[i];
        else             bit_r <= d[i];
      end
      assign q[i] = bit_r;
    end
  endgenerate
endmodule

// File: rtl/regctl_async_reg.sv
module regctl_async_reg #(
  parameter int W = 8,
  parameter regctl_pkg::rc_mode_e MODE = regctl_pkg::RC_CLR_PRE,
  parameter bit CLR_ON_B = 1'b0
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  input  logic [W-1:0] ld_d,
  input  logic         ctl_a_n,
  input  logic         ctl_b_n,
  output logic [W-1:0] q
);
  logic clr_n, pre_n, ld_n;

  regctl_route #(.MODE(MODE), .CLR_ON_B(CLR_ON_B)) u_route (
    .ctl_a_n(ctl_a_n), .ctl_b_n(ctl_b_n),
    .clr_n(clr_n), .pre_n(pre_n), .ld_n(ld_n)
  );

  regctl_cell #(.W(W)) u_cell (
    .clk(clk), .d(d), .ld_d(ld_d),
    .clr_n(clr_n), .pre_n(pre_n), .ld_n(ld_n), .q(q)
  );

  // R2
  clr_hold_chk: assert property (@(posedge clk)
    (!clr_n && $past(!clr_n)) |-> (q == '0));

  // R3
  pre_hold_chk: assert property (@(posedge clk)
    (!pre_n && $past(!pre_n) && clr_n && $past(clr_n)) |-> (q == '1));

  // R9
  ld_hold_chk: assert property (@(posedge clk)
    (!ld_n && $past(!ld_n) && clr_n && pre_n && $past(clr_n) && $past(pre_n)
     && $stable(ld_d)) |-> (q == ld_d));

  // R6
  pre_over_ld_chk: assert property (@(posedge clk)
    (!ld_n && !pre_n && $past(!ld_n) && $past(!pre_n) && clr_n && $past(clr_n))
    |-> (q == '1));
endmodule

// File: tb/regctl_async_reg_bench.sv
module regctl_async_reg_bench;
  import regctl_pkg::*;
  localparam int W = 4;
  localparam int N = 7;

  logic clk = 1'b0;
  logic [W-1:0] d = '0, ld_d = '0;
  logic a_n = 1'b1, b_n = 1'b1;
  logic [W-1:0] q [N];
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  regctl_async_reg #(.W(W), .MODE(RC_CLR), .CLR_ON_B(1'b0)) u_regctl_async_reg (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[0]));
  regctl_async_reg #(.W(W), .MODE(RC_CLR), .CLR_ON_B(1'b1)) u_regctl_async_reg_clrb (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[1]));
  regctl_async_reg #(.W(W), .MODE(RC_PRE)) u_regctl_async_reg_pre (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[2]));
  regctl_async_reg #(.W(W), .MODE(RC_CLR_PRE)) u_regctl_async_reg_cp (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[3]));
  regctl_async_reg #(.W(W), .MODE(RC_LD_CLR)) u_regctl_async_reg_lc (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[4]));
  regctl_async_reg #(.W(W), .MODE(RC_LD_PRE)) u_regctl_async_reg_lp (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[5]));
  regctl_async_reg #(.W(W), .MODE(RC_LD)) u_regctl_async_reg_ld (
    .clk(clk), .d(d), .ld_d(ld_d), .ctl_a_n(a_n), .ctl_b_n(b_n), .q(q[6]));

  // Roles per instance index, from the requirements
  function automatic void roles(input int idx, input logic a, input logic b,
                                output logic c, output logic p, output logic l);
    c = 1'b0; p = 1'b0; l = 1'b0;
    case (idx)
      0: c = !a;
      1: c = !b;
      2: p = !a;
      3: begin c = !a; p = !b; end
      4: begin l = !a; c = !b; end
      5: begin l = !a; p = !b; end
      default: l = !a;
    endcase
  endfunction

  function automatic logic [W-1:0] model(input int idx, input logic a, input logic b,
                                         input logic [W-1:0] ld, input logic [W-1:0] other);
    logic c, p, l;
    roles(idx, a, b, c, p, l);
    if (c) return '0;
    if (p) return '1;
    if (l) return ld;
    return other;
  endfunction

  function automatic string tag(input int idx, input logic a, input logic b);
    logic c, p, l;
    roles(idx, a, b, c, p, l);
    if (c && p) return "R7";
    if (l && (c || p)) return "R6";
    if (idx == 1 && c) return "R4";
    if (c) return "R2";
    if (p) return "R3";
    if (l) return "R5";
    if (!a || !b) return "R8";
    return "R1";
  endfunction

  task automatic check(input string req, input int idx,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst %0d: got %h expected %h at %0t", req, idx, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: synchronous sweep with controls idle
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); d = W'(v);
      @(posedge clk); #5;
      for (int i = 0; i < N; i++) check("R1", i, q[i], W'(v));
    end
    // Exhaustive control combination x load value
    for (int ab = 0; ab < 4; ab++) begin
      for (int lv = 0; lv < 16; lv++) begin
        logic a, b;
        logic [W-1:0] d0, d1, d2;
        a = ab[1]; b = ab[0];
        d0 = ~W'(lv); d1 = W'(lv) ^ 4'h9; d2 = W'(lv) ^ 4'h6;
        @(negedge clk); a_n = 1'b1; b_n = 1'b1; d = d0;
        @(posedge clk); #5;
        for (int i = 0; i < N; i++) check("R1", i, q[i], d0);
        ld_d = W'(lv); a_n = a; b_n = b; #1;
        for (int i = 0; i < N; i++) check(tag(i, a, b), i, q[i], model(i, a, b, W'(lv), d0));
        @(negedge clk); d = d1;
        @(posedge clk); #5;
        // R9: edge while asserted keeps forced value
        for (int i = 0; i < N; i++) check("R9", i, q[i], model(i, a, b, W'(lv), d1));
        @(negedge clk); #9; a_n = 1'b1; b_n = 1'b1; d = d2;
        @(posedge clk); #5;
        // R10: released before edge, edge captures d
        for (int i = 0; i < N; i++) check("R10", i, q[i], d2);
      end
    end
    // R10: release just after an edge
    for (int lv = 0; lv < 4; lv++) begin
      @(negedge clk); a_n = 1'b1; b_n = 1'b1; d = 4'h5;
      @(posedge clk); #5; ld_d = W'(lv) + 4'hA; a_n = 1'b0; b_n = 1'b0;
      @(negedge clk); d = 4'h3;
      @(posedge clk); #1; a_n = 1'b1; b_n = 1'b1; #4;
      for (int i = 0; i < N; i++) check("R10", i, q[i], model(i, 1'b0, 1'b0, W'(lv) + 4'hA, 4'h3));
      @(posedge clk); #5;
      for (int i = 0; i < N; i++) check("R10", i, q[i], 4'h3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule